// File: doc/BRIEF.md
# Packet-Ready DMA Event Generator with Stall Watchdog

This block sits in an FPGA between a word FIFO and the asynchronous external memory bus of a DSP. When the FIFO holds at least one whole packet of 128 words (512 bytes at 32 bits per word), it raises a DMA request line. The DSP's DMA engine then reads the packet as a run of sequential memory addresses. The block ignores the address and hands out the next FIFO word on each active read strobe.

The request line is handshaked once per packet. It drops on the first read of a packet and is not raised again until the last word of that packet has been drained. After that, the block goes back to idle and looks at the fill level again.

A watchdog watches the read burst. A stall can happen while a request waits for its first read, or partway through a packet. In either case, if no read arrives for a programmable number of cycles, the block sends a pulse on a second interrupt line. This pulse knocks the DSP out of whatever is holding up the transfer. The bus strobes are brought into the FPGA clock domain through two-flop synchronizers. Only the falling edge of the read strobe, with chip select low, counts as a read.

Top module: `pkt_evt_gen`

## Requirements
- R1: `dma_evt` rises only from idle and only when `fifo_level` is at least 128 (PKT_WORDS). A level of 127 leaves it low.
- R2: `dma_evt` falls within three clock cycles of the first synchronized read strobe falling edge of a packet.
- R3: Once a packet's first word has been read, `dma_evt` stays low until all 128 words of that packet have been read, even when the FIFO holds further packets.
- R4: A read is a falling edge of `bus_rd_n` while `bus_cs_n` is low. Each read pops exactly one FIFO word and places it on `bus_data`. Words come out in FIFO order, and there is no address input.
- R5: A read strobe that arrives while the block is idle (no request pending and no packet open) pops nothing and leaves `bus_data` unchanged.
- R6: After the 128th read of a packet, `pkt_done` is high for exactly one cycle. The block then returns to idle and raises `dma_evt` again if a further packet is present.
- R7: While a request is pending and no read has arrived for more than `stall_thresh` cycles, `stall_irq` pulses.
- R8: While a packet is partly read and the gap since the last read exceeds `stall_thresh` cycles, `stall_irq` pulses.
- R9: One stall produces exactly one `stall_irq` pulse, however long the stall lasts. Each pulse is IRQ_W (default 8) cycles wide. The watchdog re-arms only after the next read.
- R10: Read gaps shorter than `stall_thresh` cycles produce no `stall_irq` pulse.
- R11: After reset, `dma_evt`, `stall_irq`, `pkt_done` and `fifo_pop` are low and `bus_data` is zero.
- R12: A read strobe falling edge with `bus_cs_n` high is not a read. It pops nothing and does not advance the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FPGA clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_level | input | 11 | Number of words held in the FIFO |
| fifo_rd_data | input | 32 | Head word of the FIFO (first-word fall-through) |
| fifo_pop | output | 1 | One-cycle pop of the FIFO head |
| bus_cs_n | input | 1 | Asynchronous chip select, active low |
| bus_rd_n | input | 1 | Asynchronous read strobe, active low |
| bus_data | output | 32 | Word returned to the DSP |
| stall_thresh | input | 16 | Watchdog threshold in clock cycles |
| dma_evt | output | 1 | DMA request, one per packet |
| stall_irq | output | 1 | Stall interrupt pulse |
| pkt_done | output | 1 | One-cycle pulse after the last word of a packet |

## Verification
Suppose the word counter in the block drifts. Then `pkt_done` comes at the wrong read, and `dma_evt` comes back early or late. This shows at the ports on the packet's last read, or at most one packet later as a data word out of step with the expected sequence.

Suppose the packet state is wrong. Then either an idle strobe pops a word, or the request line stays high after the first read. Both show within three cycles of the strobe.

Suppose the watchdog state is wrong. Then the number or width of `stall_irq` pulses seen over a stall changes. This shows one threshold period after the stall begins.

// File: rtl/pkt_evt_pkg.sv
package pkt_evt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PEND   = 2'd1,
    ST_ACTIVE = 2'd2
  } trk_state_e;
endpackage

// File: rtl/pkt_bus_sync.sv
module pkt_bus_sync (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_async,
  input  logic rd_n_async,
  output logic rd_evt
);
  logic rd_q1, rd_q2, rd_q3;
  logic cs_q1, cs_q2;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q1 <= 1'b1;
      rd_q2 <= 1'b1;
      rd_q3 <= 1'b1;
      cs_q1 <= 1'b1;
      cs_q2 <= 1'b1;
    end else begin
      rd_q1 <= rd_n_async;
      rd_q2 <= rd_q1;
      rd_q3 <= rd_q2;
      cs_q1 <= cs_n_async;
      cs_q2 <= cs_q1;
    end
  end

  // Active (falling) strobe edge qualified by a selected chip
  assign rd_evt = rd_q3 & ~rd_q2 & ~cs_q2;
endmodule

// File: rtl/pkt_tracker.sv
module pkt_tracker
  import pkt_evt_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PKT_WORDS = 128,
  parameter int LVL_W     = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic [DATA_W-1:0] fifo_rd_data,
  input  logic              rd_evt,
  output logic              fifo_pop,
  output logic [DATA_W-1:0] bus_data,
  output logic              dma_evt,
  output logic              pkt_done,
  output logic              busy
);
  localparam int WCNT_W = $clog2(PKT_WORDS + 1);
  localparam logic [WCNT_W-1:0] LAST_WORD = WCNT_W'(PKT_WORDS - 1);
  localparam logic [LVL_W-1:0]  PKT_LVL   = LVL_W'(PKT_WORDS);

  trk_state_e        state_q;
  logic [WCNT_W-1:0] wcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      wcnt_q   <= '0;
      fifo_pop <= 1'b0;
      bus_data <= '0;
      dma_evt  <= 1'b0;
      pkt_done <= 1'b0;
    end else begin
      fifo_pop <= 1'b0;
      pkt_done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          // wait out a pop still in flight so the level is current
          if (!fifo_pop && fifo_level >= PKT_LVL) begin
            state_q <= ST_PEND;
            dma_evt <= 1'b1;
            wcnt_q  <= '0;
          end
        end
        ST_PEND, ST_ACTIVE: begin
          if (rd_evt) begin
            dma_evt  <= 1'b0;
            fifo_pop <= 1'b1;
            bus_data <= fifo_rd_data;
            if (wcnt_q == LAST_WORD) begin
              state_q  <= ST_IDLE;
              wcnt_q   <= '0;
              pkt_done <= 1'b1;
            end else begin
              state_q <= ST_ACTIVE;
              wcnt_q  <= wcnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);

  AST_EVT_NEEDS_PKT: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_evt) |-> $past(fifo_level) >= PKT_LVL); // R1
  AST_EVT_LOW_MID_PKT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACTIVE) |-> !dma_evt); // R3
  AST_NO_POP_IDLE: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> $past(state_q) != ST_IDLE); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pkt_done |=> !pkt_done); // R6
endmodule

// File: rtl/stall_watchdog.sv
module stall_watchdog #(
  parameter int CNT_W = 16,
  parameter int IRQ_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             rd_evt,
  input  logic [CNT_W-1:0] thresh,
  output logic             stall_irq
);
  localparam int PW_W = (IRQ_W > 1) ? $clog2(IRQ_W) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             fired_q;
  logic [PW_W-1:0]  left_q;
  logic             fire_now;

  assign fire_now = busy & ~rd_evt & ~fired_q & (cnt_q >= thresh);

  always_ff @(posedge clk) begin
    if (rst || !busy) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (rd_evt) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (fire_now) begin
      fired_q <= 1'b1;
    end else if (!fired_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_irq <= 1'b0;
      left_q    <= '0;
    end else if (fire_now) begin
      stall_irq <= 1'b1;
      left_q    <= PW_W'(IRQ_W - 1);
    end else if (stall_irq) begin
      if (left_q == '0) stall_irq <= 1'b0;
      else left_q <= left_q - 1'b1;
    end
  end

  AST_IRQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(stall_irq) |-> $past(busy)); // R7
  AST_NO_IRQ_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rd_evt |=> !$rose(stall_irq)); // R9
  AST_ONE_FIRE_PER_STALL: assert property (@(posedge clk) disable iff (rst)
    (fired_q && busy && !rd_evt) |=> !$rose(stall_irq)); // R9
endmodule

// File: rtl/pkt_evt_gen.sv
module pkt_evt_gen #(
  parameter int DATA_W    = 32,
  parameter int PKT_WORDS = 128,
  parameter int LVL_W     = 11,
  parameter int CNT_W     = 16,
  parameter int IRQ_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic [DATA_W-1:0] fifo_rd_data,
  output logic              fifo_pop,
  input  logic              bus_cs_n,
  input  logic              bus_rd_n,
  output logic [DATA_W-1:0] bus_data,
  input  logic [CNT_W-1:0]  stall_thresh,
  output logic              dma_evt,
  output logic              stall_irq,
  output logic              pkt_done
);
  logic rd_evt;
  logic busy;

  pkt_bus_sync u_sync (
    .clk        (clk),
    .rst        (rst),
    .cs_n_async (bus_cs_n),
    .rd_n_async (bus_rd_n),
    .rd_evt     (rd_evt)
  );

  pkt_tracker #(
    .DATA_W    (DATA_W),
    .PKT_WORDS (PKT_WORDS),
    .LVL_W     (LVL_W)
  ) u_trk (
    .clk          (clk),
    .rst          (rst),
    .fifo_level   (fifo_level),
    .fifo_rd_data (fifo_rd_data),
    .rd_evt       (rd_evt),
    .fifo_pop     (fifo_pop),
    .bus_data     (bus_data),
    .dma_evt      (dma_evt),
    .pkt_done     (pkt_done),
    .busy         (busy)
  );

  stall_watchdog #(
    .CNT_W (CNT_W),
    .IRQ_W (IRQ_W)
  ) u_wdog (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .rd_evt    (rd_evt),
    .thresh    (stall_thresh),
    .stall_irq (stall_irq)
  );
endmodule

// File: tb/pkt_evt_gen_tb_top.sv
`timescale 1ns/1ps
module pkt_evt_gen_tb_top;
  localparam int PKT = 128;
  localparam int IRQW = 8;
  localparam logic [31:0] BASE = 32'hA500_0000;
  // stall_before_word, stall_cycles, expected_pulses
  localparam int NV = 6;
  localparam int TBL [NV][3] = '{
    '{200, 0,   0},   // R10 no stall
    '{0,   100, 1},   // R7 stall before first read
    '{64,  100, 1},   // R8 mid packet
    '{127, 100, 1},   // R8 before last word
    '{10,  25,  0},   // R10 short gap
    '{30,  300, 1}    // R9 long stall, single pulse
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_cs_n = 1'b1;
  logic bus_rd_n = 1'b1;
  logic [15:0] stall_thresh = 16'd40;
  logic fifo_pop, dma_evt, stall_irq, pkt_done;
  logic [31:0] bus_data;
  logic [10:0] fifo_level;
  logic [31:0] fifo_rd_data;

  int wr_ptr = 0;
  int rd_ptr = 0;
  int pop_cnt = 0, done_cnt = 0, pulses = 0, irq_hi = 0, cycles = 0;
  int checks = 0, errors = 0;
  int exp_idx = 0;
  logic irq_prev = 1'b0;

  always #2.5 clk = ~clk;

  assign fifo_level   = 11'(wr_ptr - rd_ptr);
  assign fifo_rd_data = BASE + 32'(rd_ptr);

  pkt_evt_gen dut_i (
    .clk(clk), .rst(rst), .fifo_level(fifo_level), .fifo_rd_data(fifo_rd_data),
    .fifo_pop(fifo_pop), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_data(bus_data), .stall_thresh(stall_thresh), .dma_evt(dma_evt),
    .stall_irq(stall_irq), .pkt_done(pkt_done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst) begin
      if (fifo_pop) begin rd_ptr <= rd_ptr + 1; pop_cnt <= pop_cnt + 1; end
      if (pkt_done) done_cnt <= done_cnt + 1;
      if (stall_irq && !irq_prev) pulses <= pulses + 1;
      if (stall_irq) irq_hi <= irq_hi + 1;
      irq_prev <= stall_irq;
    end
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic cs);
    @(negedge clk);
    bus_rd_n = 1'b0; bus_cs_n = cs;
    repeat (4) @(negedge clk);
    bus_rd_n = 1'b1; bus_cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_evt();
    for (int i = 0; i < 50 && !dma_evt; i++) @(negedge clk);
  endtask

  task automatic run_packet(input int stall_at, input int stall_len, input int exp_pulses);
    int p0, d0, bad_data, evt_hi, first_bad;
    logic [31:0] first_act;
    p0 = pulses; d0 = done_cnt; bad_data = 0; evt_hi = 0; first_bad = 0; first_act = '0;
    wait_evt();
    for (int w = 0; w < PKT; w++) begin
      if (w == stall_at) repeat (stall_len) @(negedge clk);
      do_read(1'b0);
      if (bus_data != BASE + 32'(exp_idx)) begin
        if (bad_data == 0) begin first_bad = exp_idx; first_act = bus_data; end
        bad_data++;
      end
      exp_idx++;
      if (w < PKT - 1 && dma_evt) evt_hi++;
      if (w == 0) check(dma_evt == 1'b0, "R2 evt drop on first read", dma_evt, 0);
    end
    repeat (4) @(negedge clk);
    check(bad_data == 0, "R4 data order", first_act, BASE + 32'(first_bad));
    check(evt_hi == 0, "R3 evt low mid packet", evt_hi, 0);
    check(done_cnt - d0 == 1, "R6 one done pulse", done_cnt - d0, 1);
    check(pulses - p0 == exp_pulses, "R7/R8/R9/R10 stall pulses", pulses - p0, exp_pulses);
    check(dma_evt == (fifo_level >= PKT), "R6 re-evaluates level", dma_evt, fifo_level >= PKT);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!dma_evt && !stall_irq && !pkt_done && !fifo_pop && bus_data == 0,
          "R11 reset state", {dma_evt, stall_irq, pkt_done, fifo_pop}, 0);

    // R5: idle strobe with empty FIFO
    do_read(1'b0);
    repeat (3) @(negedge clk);
    check(pop_cnt == 0, "R5 idle read no pop", pop_cnt, 0);
    check(bus_data == 0, "R5 idle read data unchanged", bus_data, 0);

    // R1: level threshold
    wr_ptr = 127;
    repeat (10) @(negedge clk);
    check(dma_evt == 1'b0, "R1 level 127 no event", dma_evt, 0);
    wr_ptr = 256;
    repeat (4) @(negedge clk);
    check(dma_evt == 1'b1, "R1 full packet raises event", dma_evt, 1);

    // table-driven packets
    for (int v = 0; v < NV; v++) begin
      wr_ptr = rd_ptr + 2 * PKT;
      run_packet(TBL[v][0], TBL[v][1], TBL[v][2]);
    end
    check(irq_hi == IRQW * pulses, "R9 pulse width", irq_hi, IRQW * pulses);

    // R12: deselected strobe while a request is pending
    wait_evt();
    begin
      int p0;
      p0 = pop_cnt;
      do_read(1'b1);
      repeat (3) @(negedge clk);
      check(pop_cnt == p0, "R12 cs high no pop", pop_cnt - p0, 0);
      check(dma_evt == 1'b1, "R12 event still pending", dma_evt, 1);
    end
    run_packet(200, 0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule